// File: doc/BRIEF.md
# NAND Page Program Command Engine

This block is the device-side controller of a small-page NAND array model. A host drives an 8-bit bus with two latch strobes. On a write strobe the byte is taken as a command when the command-latch strobe is high, as an address when the address-latch strobe is high, and as data when neither is high. A program runs in two steps. A load command opens the sequence. Three address cycles follow: a column, then the page low byte, then the page high byte. Serial data then goes into a 528-byte page buffer, and a confirm command writes that buffer into the array.

After confirm, the engine holds its ready line low for a fixed number of cycles and then merges the buffer into the addressed page. The merge can only clear bits. Each page keeps two counters, one for partial programs of the main area (bytes 0..511) and one for the spare area (bytes 512..527). A program that would go past either limit is refused and reported as a failure. A status command makes every following read return the status byte until another recognised command arrives. Three pointer commands select the column base and also open an array read, which is how the host reads programmed data back.

Top module: `nand_prog_engine`

## Requirements
- R1: After reset, ready_o is 1 and io_o reads 8'hFF. Every array byte reads 8'hFF and both partial-program counters of every page are 0.
- R2: The sequence 80h, three address cycles (column, page low, page high), data bytes and then 10h programs the loaded bytes. Loading starts at the column pointer, and a later array read returns them.
- R3: Buffer bytes that were not loaded stay 8'hFF, so the program leaves those array bytes unchanged.
- R4: A program only clears bits. The stored byte becomes old AND loaded, so a bit that is already 0 stays 0.
- R5: A 10h that is not preceded by a completed 80h-plus-three-address sequence is ignored and leaves ready_o at 1. This covers a 10h after reset, after a read, and after FFh.
- R6: An accepted 10h drives ready_o low for exactly T_PROG cycles, starting at the clock edge that latches it.
- R7: While ready_o is 0, only 70h and FFh act. Every other command, address byte or data byte is ignored. Status mode survives into the ready state, and the page being programmed is not disturbed.
- R8: The status byte is {1, ready, 5'b00000, fail}. Bit 6 is 0 while busy and 1 when ready, and bit 0 is 1 when the last program failed. It reads 8'h80 while busy, 8'hC0 after a pass and 8'hC1 after a fail.
- R9: After 70h, io_o keeps returning status across read strobes and across ignored commands, such as 33h or a stray 10h. One of 00h, 01h, 50h, 80h or FFh leaves status mode; io_o then reads 8'hFF until a read address is complete.
- R10: Each page accepts at most MAIN_LIMIT (2) programs that touch the main area. A further one sets fail (status 8'hC1) and leaves the page unchanged.
- R11: Each page accepts at most SPARE_LIMIT (3) programs that touch the spare area, counted apart from the main area. A further one sets fail and leaves the page unchanged.
- R12: The first address byte is an offset from a base chosen by the last pointer command: 00h gives 0, 01h gives 256 and 50h gives 512. The pointer advances on each data byte and each array read strobe, stops after byte 527, and ignores further data. Reads past the end return 8'hFF.
- R13: FFh clears the buffer to all-ones and returns the engine to idle. During a load this makes a following 10h ignored. During busy it raises ready_o at the next edge, the array is not changed and the status reads 8'hC0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cle_i | input | 1 | Command-latch strobe: the bus byte is a command |
| ale_i | input | 1 | Address-latch strobe: the bus byte is an address |
| we_i | input | 1 | Write strobe, one cycle per bus byte |
| re_i | input | 1 | Read strobe: advances the array read pointer |
| io_i | input | 8 | Bus byte from the host |
| io_o | output | 8 | Status byte, array byte or 8'hFF |
| ready_o | output | 1 | 1 when ready, 0 while programming |

## Verification
A wrong pending-fail or counter state stays hidden until the next confirm completes. It then shows as a wrong bit 0 in the status byte, and as a page that did or did not change when read back, T_PROG cycles after the 10h. A wrong phase in the command decoder shows at once: ready_o falls on a stray 10h, or fails to fall on a valid one. A wrong column pointer shows on the first read of the programmed page, as data at a shifted offset or as 8'hFF where a byte was expected.

// File: rtl/nand_prog_pkg.sv
`timescale 1ns/1ps
package nand_prog_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_LOAD, PH_BUSY} phase_e;
  typedef enum logic [1:0] {OUT_NONE, OUT_STATUS, OUT_ARRAY} out_e;

  localparam logic [7:0] CMD_PTR_LO  = 8'h00;
  localparam logic [7:0] CMD_PTR_HI  = 8'h01;
  localparam logic [7:0] CMD_PTR_SP  = 8'h50;
  localparam logic [7:0] CMD_LOAD    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
endpackage

// File: rtl/nand_busy_timer.sv
`timescale 1ns/1ps
module nand_busy_timer #(
  parameter int T_PROG = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(T_PROG + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (abort_i)         cnt_q <= '0;
    else if (start_i)         cnt_q <= TW'(T_PROG);
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign busy_o = (cnt_q != '0);
  // last busy cycle: commit happens on this edge
  assign done_o = (cnt_q == TW'(1));
endmodule

// File: rtl/nand_cmd_fsm.sv
`timescale 1ns/1ps
module nand_cmd_fsm
  import nand_prog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] io_i,
  input  logic       timer_done_i,
  output out_e       out_o,
  output logic [1:0] base_sel_o,
  output logic       addr_we_o,
  output logic [1:0] addr_idx_o,
  output logic       clr_buf_o,
  output logic       data_we_o,
  output logic       start_o,
  output logic       abort_o
);
  phase_e     phase_q, phase_d;
  out_e       out_q, out_d;
  logic [1:0] base_q, base_d;
  logic [1:0] idx_q, idx_d;
  logic       prog_q, prog_d;
  logic       cmd_v, adr_v, dat_v;

  assign cmd_v = we_i &  cle_i & ~ale_i;
  assign adr_v = we_i &  ale_i & ~cle_i;
  assign dat_v = we_i & ~cle_i & ~ale_i;

  always_comb begin
    phase_d   = phase_q;
    out_d     = out_q;
    base_d    = base_q;
    idx_d     = idx_q;
    prog_d    = prog_q;
    addr_we_o = 1'b0;
    clr_buf_o = 1'b0;
    data_we_o = 1'b0;
    start_o   = 1'b0;
    abort_o   = 1'b0;
    if (phase_q == PH_BUSY) begin
      if (timer_done_i) phase_d = PH_IDLE;
      if (cmd_v && io_i == CMD_STATUS) begin
        out_d = OUT_STATUS;
      end else if (cmd_v && io_i == CMD_RESET) begin
        abort_o   = 1'b1;
        clr_buf_o = 1'b1;
        phase_d   = PH_IDLE;
        out_d     = OUT_NONE;
        base_d    = 2'd0;
      end
    end else if (cmd_v) begin
      case (io_i)
        CMD_PTR_LO, CMD_PTR_HI, CMD_PTR_SP: begin
          base_d  = (io_i == CMD_PTR_HI) ? 2'd1 : (io_i == CMD_PTR_SP) ? 2'd2 : 2'd0;
          phase_d = PH_ADDR;
          prog_d  = 1'b0;
          idx_d   = 2'd0;
          out_d   = OUT_NONE;
        end
        CMD_LOAD: begin
          clr_buf_o = 1'b1;
          phase_d   = PH_ADDR;
          prog_d    = 1'b1;
          idx_d     = 2'd0;
          out_d     = OUT_NONE;
        end
        CMD_CONFIRM: begin
          if (phase_q == PH_LOAD) begin
            start_o = 1'b1;
            phase_d = PH_BUSY;
          end
        end
        CMD_STATUS: begin
          out_d   = OUT_STATUS;
          phase_d = PH_IDLE;
        end
        CMD_RESET: begin
          clr_buf_o = 1'b1;
          phase_d   = PH_IDLE;
          out_d     = OUT_NONE;
          base_d    = 2'd0;
        end
        default: ;
      endcase
    end else if (adr_v && phase_q == PH_ADDR) begin
      addr_we_o = 1'b1;
      idx_d     = 2'(idx_q + 2'd1);
      if (idx_q == 2'd2) begin
        idx_d   = 2'd0;
        phase_d = prog_q ? PH_LOAD : PH_IDLE;
        if (!prog_q) out_d = OUT_ARRAY;
      end
    end else if (dat_v && phase_q == PH_LOAD) begin
      data_we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      out_q   <= OUT_NONE;
      base_q  <= 2'd0;
      idx_q   <= 2'd0;
      prog_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      out_q   <= out_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      prog_q  <= prog_d;
    end
  end

  assign out_o      = out_q;
  assign base_sel_o = base_q;
  assign addr_idx_o = idx_q;
endmodule

// File: rtl/nand_page_buf.sv
`timescale 1ns/1ps
module nand_page_buf #(
  parameter int PAGE_BYTES = 528,
  parameter int MAIN_BYTES = 512,
  parameter int COL_W      = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    col_load_i,
  input  logic [COL_W-1:0]        col_val_i,
  input  logic                    wr_i,
  input  logic                    adv_i,
  input  logic [7:0]              din_i,
  output logic [COL_W-1:0]        col_o,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic                    main_touch_o,
  output logic                    spare_touch_o
);
  logic [7:0]       byte_q [PAGE_BYTES];
  logic [COL_W-1:0] col_q;
  logic             main_q, spare_q;
  logic             in_page, in_main;

  assign in_page = (col_q < COL_W'(PAGE_BYTES));
  assign in_main = (col_q < COL_W'(MAIN_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) byte_q[i] <= 8'hFF;
    end else if (clr_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) byte_q[i] <= 8'hFF;
    end else if (wr_i && in_page) begin
      byte_q[col_q] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      main_q  <= 1'b0;
      spare_q <= 1'b0;
    end else begin
      if (clr_i) begin
        main_q  <= 1'b0;
        spare_q <= 1'b0;
      end else if (wr_i && in_page) begin
        if (in_main) main_q  <= 1'b1;
        else         spare_q <= 1'b1;
      end
      if (col_load_i)                   col_q <= col_val_i;
      else if ((wr_i || adv_i) && in_page) col_q <= col_q + COL_W'(1);
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign data_o[g*8 +: 8] = byte_q[g];
  end

  assign col_o         = col_q;
  assign main_touch_o  = main_q;
  assign spare_touch_o = spare_q;
endmodule

// File: rtl/nand_array.sv
`timescale 1ns/1ps
module nand_array #(
  parameter int NUM_PAGES   = 4,
  parameter int PAGE_BYTES  = 528,
  parameter int MAIN_LIMIT  = 2,
  parameter int SPARE_LIMIT = 3,
  parameter int PAGE_W      = 2,
  parameter int COL_W       = 10,
  parameter int CNT_W       = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic                    main_touch_i,
  input  logic                    spare_touch_i,
  input  logic [COL_W-1:0]        rd_col_i,
  output logic [7:0]              rd_data_o,
  output logic                    limit_hit_o
);
  logic [7:0]       mem_q       [NUM_PAGES][PAGE_BYTES];
  logic [CNT_W-1:0] main_cnt_q  [NUM_PAGES];
  logic [CNT_W-1:0] spare_cnt_q [NUM_PAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++) mem_q[p][b] <= 8'hFF;
    end else if (commit_i) begin
      // cells can only be pulled from 1 to 0
      for (int b = 0; b < PAGE_BYTES; b++)
        mem_q[page_i][b] <= mem_q[page_i][b] & data_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        main_cnt_q[p]  <= '0;
        spare_cnt_q[p] <= '0;
      end
    end else if (commit_i) begin
      if (main_touch_i)  main_cnt_q[page_i]  <= main_cnt_q[page_i]  + CNT_W'(1);
      if (spare_touch_i) spare_cnt_q[page_i] <= spare_cnt_q[page_i] + CNT_W'(1);
    end
  end

  assign limit_hit_o = (main_touch_i  && main_cnt_q[page_i]  >= CNT_W'(MAIN_LIMIT)) ||
                       (spare_touch_i && spare_cnt_q[page_i] >= CNT_W'(SPARE_LIMIT));

  assign rd_data_o = (rd_col_i < COL_W'(PAGE_BYTES)) ? mem_q[page_i][rd_col_i] : 8'hFF;
endmodule

// File: rtl/nand_prog_engine.sv
`timescale 1ns/1ps
module nand_prog_engine
  import nand_prog_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int MAIN_BYTES  = 512,
  parameter int NUM_PAGES   = 4,
  parameter int T_PROG      = 200,
  parameter int MAIN_LIMIT  = 2,
  parameter int SPARE_LIMIT = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       ready_o
);
  localparam int COL_W  = $clog2(PAGE_BYTES + 1);
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int LIM_MX = (MAIN_LIMIT > SPARE_LIMIT) ? MAIN_LIMIT : SPARE_LIMIT;
  localparam int CNT_W  = $clog2(LIM_MX + 1);

  out_e                    out_mode;
  logic [1:0]              base_sel, addr_idx;
  logic                    addr_we, clr_buf, data_we, start, abort;
  logic                    busy, done, commit, limit_hit;
  logic                    pend_q, fail_q, status_sel, rd_adv;
  logic [PAGE_W-1:0]       page_q;
  logic [COL_W:0]          col_base, col_sum;
  logic [COL_W-1:0]        col_val, col;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic                    main_touch, spare_touch;
  logic [7:0]              rd_data, status;

  nand_cmd_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .cle_i        (cle_i),
    .ale_i        (ale_i),
    .io_i         (io_i),
    .timer_done_i (done),
    .out_o        (out_mode),
    .base_sel_o   (base_sel),
    .addr_we_o    (addr_we),
    .addr_idx_o   (addr_idx),
    .clr_buf_o    (clr_buf),
    .data_we_o    (data_we),
    .start_o      (start),
    .abort_o      (abort)
  );

  nand_busy_timer #(.T_PROG(T_PROG)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_comb begin
    case (base_sel)
      2'd1:    col_base = (COL_W+1)'(MAIN_BYTES / 2);
      2'd2:    col_base = (COL_W+1)'(MAIN_BYTES);
      default: col_base = '0;
    endcase
    col_sum = col_base + (COL_W+1)'(io_i);
    col_val = (col_sum > (COL_W+1)'(PAGE_BYTES)) ? COL_W'(PAGE_BYTES) : col_sum[COL_W-1:0];
  end

  // only the page-select bits of the row are kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          page_q <= '0;
    else if (addr_we && addr_idx == 2'd1) page_q <= io_i[PAGE_W-1:0];
  end

  assign rd_adv = re_i && (out_mode == OUT_ARRAY) && !busy;

  nand_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .MAIN_BYTES (MAIN_BYTES),
    .COL_W      (COL_W)
  ) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr_buf),
    .col_load_i    (addr_we && addr_idx == 2'd0),
    .col_val_i     (col_val),
    .wr_i          (data_we),
    .adv_i         (rd_adv),
    .din_i         (io_i),
    .col_o         (col),
    .data_o        (buf_data),
    .main_touch_o  (main_touch),
    .spare_touch_o (spare_touch)
  );

  nand_array #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_BYTES  (PAGE_BYTES),
    .MAIN_LIMIT  (MAIN_LIMIT),
    .SPARE_LIMIT (SPARE_LIMIT),
    .PAGE_W      (PAGE_W),
    .COL_W       (COL_W),
    .CNT_W       (CNT_W)
  ) u_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .page_i        (page_q),
    .data_i        (buf_data),
    .main_touch_i  (main_touch),
    .spare_touch_i (spare_touch),
    .rd_col_i      (col),
    .rd_data_o     (rd_data),
    .limit_hit_o   (limit_hit)
  );

  // limit verdict taken at confirm, published when the busy window closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (start) begin
      pend_q <= limit_hit;
      fail_q <= 1'b0;
    end else if (done && !abort) begin
      fail_q <= pend_q;
    end
  end

  assign commit     = done && !abort && !pend_q;
  assign ready_o    = !busy;
  assign status     = {1'b1, ready_o, 5'b00000, fail_q};
  assign status_sel = (out_mode == OUT_STATUS);

  always_comb begin
    if (status_sel)                            io_o = status;
    else if (out_mode == OUT_ARRAY && ready_o) io_o = rd_data;
    else                                       io_o = 8'hFF;
  end
endmodule

// File: rtl/nand_prog_chk.sv
`timescale 1ns/1ps
module nand_prog_chk #(
  parameter int T_PROG = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_i,
  input logic [7:0] io_i,
  input logic [7:0] io_o,
  input logic       ready_o,
  input logic       status_mode_i
);
  localparam int LW = $clog2(T_PROG + 1) + 1;

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt <= '0;
    else if (ready_o)         low_cnt <= '0;
    else if (low_cnt != '1)   low_cnt <= low_cnt + LW'(1);
  end

  // R8
  busy_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_mode_i && !ready_o) |-> io_o == 8'h80);

  // R8
  ready_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_mode_i && ready_o) |-> (io_o[7:6] == 2'b11 && io_o[5:1] == 5'd0));

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(we_i && cle_i && !ale_i && io_i == 8'h10));

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> low_cnt < LW'(T_PROG));

  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(we_i && cle_i && !ale_i && io_i == 8'hFF))
      |-> $past(low_cnt) == LW'(T_PROG - 1));

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && we_i && io_i != 8'hFF && low_cnt < LW'(T_PROG - 1)) |=> !ready_o);

  // R13
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && we_i && cle_i && !ale_i && io_i == 8'hFF) |=> ready_o);
endmodule

bind nand_prog_engine nand_prog_chk #(.T_PROG(T_PROG)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cle_i         (cle_i),
  .ale_i         (ale_i),
  .we_i          (we_i),
  .io_i          (io_i),
  .io_o          (io_o),
  .ready_o       (ready_o),
  .status_mode_i (status_sel)
);

// File: tb/sim_nand_prog_engine.sv
`timescale 1ns/1ps
module sim_nand_prog_engine;
  localparam int TP = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cle = 1'b0, ale = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] io = 8'h00;
  logic [7:0] io_o;
  logic       ready_o;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  nand_prog_engine #(.T_PROG(TP)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .cle_i (cle), .ale_i (ale),
    .we_i (we), .re_i (re), .io_i (io), .io_o (io_o), .ready_o (ready_o)
  );

  // {page, pointer cmd, column, data, expected status, expected readback}
  localparam logic [47:0] VEC [0:8] = '{
    48'h00_00_05_A5_C0_A5,  // R2 first main program
    48'h00_00_05_0F_C0_05,  // R4 AND merge
    48'h00_00_06_00_C1_FF,  // R10 third main program refused
    48'h01_01_03_3C_C0_3C,  // R12 base 256
    48'h01_50_00_11_C0_11,  // R11 spare 1
    48'h01_50_01_22_C0_22,  // R11 spare 2
    48'h01_50_02_33_C0_33,  // R11 spare 3
    48'h01_50_03_44_C1_FF,  // R11 fourth spare refused
    48'h01_00_09_77_C0_77   // R10 main count independent of spare
  };

  task automatic bus(input logic c, a, w, r, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; we = w; re = r; io = d;
    @(negedge clk);
    cle = 0; ale = 0; we = 0; re = 0; io = 8'h00;
  endtask
  task automatic cmd(input logic [7:0] d); bus(1, 0, 1, 0, d); endtask
  task automatic adr(input logic [7:0] d); bus(0, 1, 1, 0, d); endtask
  task automatic dat(input logic [7:0] d); bus(0, 0, 1, 0, d); endtask
  task automatic rdp(); bus(0, 0, 0, 1, 8'h00); endtask

  task automatic chk8(input string req, input logic [7:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready_o && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup_read(input logic [7:0] ptr, col, pg);
    cmd(ptr); adr(col); adr(pg); adr(8'h00);
  endtask

  task automatic prog1(input logic [7:0] ptr, col, pg, d);
    cmd(ptr); cmd(8'h80); adr(col); adr(pg); adr(8'h00); dat(d); cmd(8'h10);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk8("R1 ready", {7'd0, ready_o}, 8'h01);
    chk8("R1 io idle", io_o, 8'hFF);
    // R5 confirm without load
    cmd(8'h10);
    chk8("R5 ready after lone 10h", {7'd0, ready_o}, 8'h01);
    cmd(8'h70);
    chk8("R1 status after reset", io_o, 8'hC0);
    setup_read(8'h00, 8'h07, 8'h02);
    chk8("R1 array erased", io_o, 8'hFF);

    // table walk: R2 R4 R10 R11 R12
    for (int i = 0; i < 9; i++) begin
      logic [7:0] pg, pt, cl, dt, es, er;
      {pg, pt, cl, dt, es, er} = VEC[i];
      prog1(pt, cl, pg, dt);
      wait_ready(n);
      cmd(8'h70);
      chk8($sformatf("R2/R10/R11 vector %0d status", i), io_o, es);
      setup_read(pt, cl, pg);
      chk8($sformatf("R2/R4/R12 vector %0d readback", i), io_o, er);
    end

    // R7 R8 busy behaviour, page 2 col 40
    prog1(8'h00, 8'd40, 8'h02, 8'h5A);
    cmd(8'h70);
    chk8("R8 busy status", io_o, 8'h80);
    cmd(8'h80); adr(8'h01); dat(8'h00); cmd(8'h00);
    chk8("R7 still busy", {7'd0, ready_o}, 8'h00);
    wait_ready(n);
    chk8("R7 status mode kept after busy", io_o, 8'hC0);
    setup_read(8'h00, 8'd40, 8'h02);
    chk8("R7 page programmed", io_o, 8'h5A);
    setup_read(8'h00, 8'd1, 8'h02);
    chk8("R7 busy data ignored", io_o, 8'hFF);

    // R3 R6 two bytes, page 2 col 10..11
    cmd(8'h00); cmd(8'h80); adr(8'd10); adr(8'h02); adr(8'h00);
    dat(8'hAA); dat(8'hBB); cmd(8'h10);
    wait_ready(n);
    chk8("R6 busy length", 8'(n), 8'(TP));
    setup_read(8'h00, 8'd9, 8'h02);
    chk8("R3 byte before unchanged", io_o, 8'hFF);
    rdp(); chk8("R2 first byte", io_o, 8'hAA);
    rdp(); chk8("R2 second byte", io_o, 8'hBB);
    rdp(); chk8("R3 byte after unchanged", io_o, 8'hFF);

    // R9 sticky status
    cmd(8'h70);
    rdp(); rdp();
    chk8("R9 status after reads", io_o, 8'hC0);
    cmd(8'h33);
    chk8("R9 status after unknown cmd", io_o, 8'hC0);
    cmd(8'h10);
    chk8("R9 status after stray 10h", io_o, 8'hC0);
    chk8("R5 no busy on stray 10h", {7'd0, ready_o}, 8'h01);
    cmd(8'h00);
    chk8("R9 pointer cmd leaves status", io_o, 8'hFF);

    // R12 pointer stops at 527, page 3 spare col 14 (=526)
    cmd(8'h50); cmd(8'h80); adr(8'd14); adr(8'h03); adr(8'h00);
    dat(8'h01); dat(8'h02); dat(8'h03); dat(8'h04); cmd(8'h10);
    wait_ready(n);
    setup_read(8'h50, 8'd14, 8'h03);
    chk8("R12 byte 526", io_o, 8'h01);
    rdp(); chk8("R12 byte 527", io_o, 8'h02);
    rdp(); chk8("R12 read past end", io_o, 8'hFF);
    setup_read(8'h00, 8'd0, 8'h03);
    chk8("R12 overflow did not wrap", io_o, 8'hFF);

    // R13 abort during load
    cmd(8'h80); adr(8'd20); adr(8'h02); adr(8'h00); dat(8'h00);
    cmd(8'hFF); cmd(8'h10);
    chk8("R13 confirm after reset ignored", {7'd0, ready_o}, 8'h01);
    setup_read(8'h00, 8'd20, 8'h02);
    chk8("R13 aborted load not written", io_o, 8'hFF);

    // R13 abort during busy
    prog1(8'h00, 8'd0, 8'h03, 8'h00);
    @(negedge clk); @(negedge clk);
    chk8("R13 busy before abort", {7'd0, ready_o}, 8'h00);
    cmd(8'hFF);
    chk8("R13 ready after abort", {7'd0, ready_o}, 8'h01);
    cmd(8'h70);
    chk8("R13 status after abort", io_o, 8'hC0);
    setup_read(8'h00, 8'd0, 8'h03);
    chk8("R13 aborted program not written", io_o, 8'hFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule